// File: doc/BRIEF.md
# DMA activation router for interrupt sources

This block sits between a set of peripheral interrupt request flags and a bank of DMA channels. Each channel picks one source through a select field and carries two configuration bits. The enable bit says whether the channel takes requests at all. The steer bit says whether the DMA owns the source alone (steer=1) or shares it with the processor side (steer=0). The block watches each source for a new request and raises a pending bit on every enabled channel that selects it. It then issues channel start pulses one at a time in fixed priority order, channel 0 first.

The router also decides which requests still reach the processor or the secondary transfer controller. It strobes the clear line of a source flag when the DMA has consumed that request. Most sources clear when their leading DMA channel is started. A subset of sources (converter-done, transmit-empty and receive-full style peripherals, marked by a parameter mask) clear only when the channel reports that its transfer touched the peripheral's data register. Channel priority is independent of any processor interrupt priority.

Top module: `dma_act_router`

## Requirements
- R1: `cpu_req[s]` equals `src_req[s]` unless an enabled channel with steer=1 selects source s, in which case `cpu_req[s]` is 0. This path is combinational.
- R2: A 0-to-1 change of `src_req[s]` sets a pending request on every enabled channel whose select field equals s. A flag that stays high produces exactly one start per channel.
- R3: A channel whose request edge is applied before clock edge N is started by a one-cycle `ch_start` pulse after edge N+1. At most one `ch_start` bit is high in any cycle.
- R4: When several enabled channels share a source, they are started in consecutive cycles, lowest channel index first.
- R5: For a source outside the register-access mask, `src_clr[s]` pulses in the same cycle as the start of the lowest-index enabled channel with steer=1 that selects s. No clear pulse accompanies the start of any other channel.
- R6: A channel with steer=0 is still started, but its start never clears the flag, and the request is still forwarded on `cpu_req`.
- R7: For a source in the register-access mask (default sources 0, 1 and 2), a start produces no clear. A `ch_reg_acc[c]` strobe from an enabled steer=1 channel selecting s makes `src_clr[s]` pulse one cycle later.
- R8: A disabled channel never gets a pending request or a start. Disabling a channel drops any request it still has pending, and its source is forwarded on `cpu_req`.
- R9: While reset is held and immediately after it, `ch_start` and `src_clr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NSRC | Per-source interrupt request flags (level) |
| ch_sel | input | NCH*SEL_W | Source select per channel, channel c in bits [c*SEL_W +: SEL_W] |
| ch_en | input | NCH | Per-channel enable |
| ch_steer | input | NCH | Per-channel steer: 1 = DMA-exclusive, 0 = shared with the processor |
| ch_reg_acc | input | NCH | Strobe: the channel's transfer accessed the source's data register |
| ch_start | output | NCH | One-cycle channel start pulses |
| src_clr | output | NSRC | One-cycle flag-clear strobes per source |
| cpu_req | output | NSRC | Requests forwarded to the processor or secondary controller |

## Verification
The assertions assume the transfer engine raises `ch_reg_acc` only after a start and one cycle at a time. They also assume every input is driven to a known value from the first clock. The stimulus meets this by changing configuration and flags only on falling edges and pulsing the access strobe for single cycles. Between scenarios it lowers every flag and disables every channel, so a source never rises again before its previous request has been served.

// File: rtl/dma_act_pkg.sv
package dma_act_pkg;
    localparam int DEF_NCH  = 4;
    localparam int DEF_NSRC = 8;
    // sources whose flag clears only on data register access
    localparam logic [DEF_NSRC-1:0] DEF_ACC_MASK = 8'b0000_0111;
endpackage

// File: rtl/dma_act_prio.sv
module dma_act_prio #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) gnt = N'(1) << i;
        end
    end
endmodule

// File: rtl/dma_act_claim.sv
module dma_act_claim #(
    parameter int NCH   = 4,
    parameter int NSRC  = 8,
    parameter int SEL_W = 3
) (
    input  logic [NCH*SEL_W-1:0] ch_sel,
    input  logic [NCH-1:0]       ch_en,
    input  logic [NCH-1:0]       ch_steer,
    output logic [NSRC-1:0]      claim_src,
    output logic [NCH-1:0]       lead_ch
);
    always_comb begin
        claim_src = '0;
        lead_ch   = '0;
        for (int c = 0; c < NCH; c++) begin
            if (ch_en[c] && ch_steer[c]) begin
                if (!claim_src[ch_sel[c*SEL_W +: SEL_W]]) lead_ch[c] = 1'b1;
                claim_src[ch_sel[c*SEL_W +: SEL_W]] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_act_router.sv
module dma_act_router
    import dma_act_pkg::*;
#(
    parameter int                NCH      = DEF_NCH,
    parameter int                NSRC     = DEF_NSRC,
    parameter logic [NSRC-1:0]   ACC_MASK = DEF_ACC_MASK,
    localparam int               SEL_W    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC-1:0]      src_req,
    input  logic [NCH*SEL_W-1:0] ch_sel,
    input  logic [NCH-1:0]       ch_en,
    input  logic [NCH-1:0]       ch_steer,
    input  logic [NCH-1:0]       ch_reg_acc,
    output logic [NCH-1:0]       ch_start,
    output logic [NSRC-1:0]      src_clr,
    output logic [NSRC-1:0]      cpu_req
);
    typedef struct packed {
        logic [NSRC-1:0] prev;
        logic [NCH-1:0]  pend;
        logic [NCH-1:0]  start;
        logic [NSRC-1:0] clr;
    } state_t;

    state_t st_d, st_q;

    logic [NSRC-1:0] claim_src;
    logic [NCH-1:0]  lead_ch;
    logic [NCH-1:0]  pend_act;
    logic [NCH-1:0]  gnt;

    dma_act_claim #(.NCH(NCH), .NSRC(NSRC), .SEL_W(SEL_W)) claim_i (
        .ch_sel    (ch_sel),
        .ch_en     (ch_en),
        .ch_steer  (ch_steer),
        .claim_src (claim_src),
        .lead_ch   (lead_ch)
    );

    assign pend_act = st_q.pend & ch_en;

    dma_act_prio #(.N(NCH)) prio_i (
        .req (pend_act),
        .gnt (gnt)
    );

    always_comb begin
        logic [NSRC-1:0]  rise;
        logic [NCH-1:0]   set;
        logic [SEL_W-1:0] s;
        st_d      = st_q;
        rise      = src_req & ~st_q.prev;
        set       = '0;
        st_d.clr  = '0;
        st_d.prev = src_req;
        for (int c = 0; c < NCH; c++) begin
            s = ch_sel[c*SEL_W +: SEL_W];
            if (ch_en[c] && rise[s]) set[c] = 1'b1;
            // clear at start for ordinary sources, leading steered channel only
            if (gnt[c] && lead_ch[c] && !ACC_MASK[s]) st_d.clr[s] = 1'b1;
            // clear on register access for access-class sources
            if (ch_reg_acc[c] && ch_en[c] && ch_steer[c] && ACC_MASK[s])
                st_d.clr[s] = 1'b1;
        end
        st_d.pend  = (pend_act & ~gnt) | set;
        st_d.start = gnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ch_start = st_q.start;
    assign src_clr  = st_q.clr;
    assign cpu_req  = src_req & ~claim_src;
endmodule

// File: rtl/dma_act_router_chk.sv
module dma_act_router_chk #(
    parameter int NCH  = 4,
    parameter int NSRC = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_req,
    input logic [NCH-1:0]  ch_en,
    input logic [NCH-1:0]  ch_reg_acc,
    input logic [NCH-1:0]  ch_start,
    input logic [NSRC-1:0] src_clr,
    input logic [NSRC-1:0] cpu_req
);
    // R3
    start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_start));

    // R8
    start_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_start != '0) |-> ((ch_start & ~$past(ch_en)) == '0));

    // R2
    start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_start != '0) |=> ((ch_start & $past(ch_start)) == '0));

    // R1
    fwd_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req & ~src_req) == '0);

    // R5
    clr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_clr != '0) |-> (ch_start != '0 || $past(ch_reg_acc) != '0));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (ch_start == '0 && src_clr == '0));
endmodule

bind dma_act_router dma_act_router_chk #(.NCH(NCH), .NSRC(NSRC)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_req    (src_req),
    .ch_en      (ch_en),
    .ch_reg_acc (ch_reg_acc),
    .ch_start   (ch_start),
    .src_clr    (src_clr),
    .cpu_req    (cpu_req)
);

// File: tb/dma_act_router_tb_top.sv
module dma_act_router_tb_top;
    localparam int NCH = 4, NSRC = 8, SW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_req = '0;
    logic [NCH*SW-1:0] ch_sel = '0;
    logic [NCH-1:0]  ch_en = '0, ch_steer = '0, ch_reg_acc = '0;
    logic [NCH-1:0]  ch_start;
    logic [NSRC-1:0] src_clr, cpu_req;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dma_act_router dut_i (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .ch_sel(ch_sel),
        .ch_en(ch_en), .ch_steer(ch_steer), .ch_reg_acc(ch_reg_acc),
        .ch_start(ch_start), .src_clr(src_clr), .cpu_req(cpu_req)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cfg(input int c, input int s, input bit en, input bit st);
        ch_sel[c*SW +: SW] = SW'(s);
        ch_en[c]    = en;
        ch_steer[c] = st;
    endtask

    task automatic idle();
        src_req = '0; ch_en = '0; ch_steer = '0; ch_reg_acc = '0;
        step(3);
    endtask

    task automatic t_reset();
        step(2);
        check(ch_start == 0 && src_clr == 0, "R9 in reset", {ch_start, src_clr}, 0);
        rst_n = 1'b1;
        step(1);
        check(ch_start == 0 && src_clr == 0, "R9 after reset", {ch_start, src_clr}, 0);
        check(cpu_req == 0, "R9 cpu_req idle", cpu_req, 0);
    endtask

    task automatic t_forward();
        cfg(0, 5, 1, 0);
        src_req[5] = 1'b1;
        #1 check(cpu_req == 8'h20, "R1 shared forwarded", cpu_req, 8'h20);
        ch_steer[0] = 1'b1;
        #1 check(cpu_req == 8'h00, "R1 claimed blocked", cpu_req, 8'h00);
        ch_en[0] = 1'b0;
        #1 check(cpu_req == 8'h20, "R8 disabled forwarded", cpu_req, 8'h20);
        idle();
    endtask

    task automatic t_single();
        cfg(1, 4, 1, 1);
        src_req[4] = 1'b1;
        step(1);
        check(ch_start == 0, "R3 no start yet", ch_start, 0);
        step(1);
        check(ch_start == 4'b0010, "R3 start ch1", ch_start, 4'b0010);
        check(src_clr == 8'h10, "R5 clear with start", src_clr, 8'h10);
        step(1);
        check(ch_start == 0 && src_clr == 0, "R3 single pulse", {ch_start, src_clr}, 0);
        step(4);
        check(ch_start == 0, "R2 held flag once", ch_start, 0);
        idle();
    endtask

    task automatic t_shared();
        logic [NCH-1:0]  exp_s [4] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000};
        logic [NSRC-1:0] exp_c [4] = '{8'h40, 8'h00, 8'h00, 8'h00};
        cfg(0, 6, 1, 1); cfg(1, 6, 1, 0); cfg(2, 6, 1, 1); cfg(3, 6, 1, 1);
        src_req[6] = 1'b1;
        step(1);
        check(cpu_req == 0, "R1 shared source claimed", cpu_req, 0);
        for (int k = 0; k < 4; k++) begin
            step(1);
            check(ch_start == exp_s[k], "R4 priority order", ch_start, exp_s[k]);
            check(src_clr == exp_c[k], "R5 only leader clears", src_clr, exp_c[k]);
        end
        step(1);
        check(ch_start == 0, "R4 sequence ends", ch_start, 0);
        idle();
    endtask

    task automatic t_steer0();
        cfg(2, 3, 1, 0);
        src_req[3] = 1'b1;
        step(2);
        check(ch_start == 4'b0100, "R6 start with steer0", ch_start, 4'b0100);
        check(src_clr == 0, "R6 no clear", src_clr, 0);
        check(cpu_req == 8'h08, "R6 still forwarded", cpu_req, 8'h08);
        idle();
    endtask

    task automatic t_access();
        cfg(0, 1, 1, 1);
        src_req[1] = 1'b1;
        step(2);
        check(ch_start == 4'b0001, "R7 start ch0", ch_start, 4'b0001);
        check(src_clr == 0, "R7 no clear at start", src_clr, 0);
        ch_reg_acc = 4'b0001;
        step(1);
        ch_reg_acc = '0;
        check(src_clr == 8'h02, "R7 clear on access", src_clr, 8'h02);
        step(1);
        check(src_clr == 0, "R7 clear one cycle", src_clr, 0);
        idle();
    endtask

    task automatic t_disabled();
        cfg(3, 7, 0, 1);
        src_req[7] = 1'b1;
        step(4);
        check(ch_start == 0, "R8 disabled no start", ch_start, 0);
        check(cpu_req == 8'h80, "R8 disabled forwards", cpu_req, 8'h80);
        idle();
        cfg(3, 7, 1, 1);
        src_req[7] = 1'b1;
        step(1);
        ch_en[3] = 1'b0;
        step(1);
        check(ch_start == 0, "R8 pending dropped", ch_start, 0);
        ch_en[3] = 1'b1;
        step(3);
        check(ch_start == 0, "R8 no stale start", ch_start, 0);
        idle();
    endtask

    initial begin
        t_reset();
        t_forward();
        t_single();
        t_shared();
        t_steer0();
        t_access();
        t_disabled();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule